// File: doc/BRIEF.md
# Task-File Byte-Lane Access Decoder

This block is the host-facing register port of an ATA-style storage device that sits in a PC Card style socket. On each access strobe it reads the two active-low card enables, address bit 0 and a four-bit register offset. From these it decides whether the cycle reaches the 16-bit data register, the shared error/feature location, or nothing. It then places the addressed bytes on the correct lanes of the 16-bit host bus.

The data register is a window onto a 512-byte sector buffer held in two byte-wide banks, so block RAM can be inferred. Each data access moves a word or a byte at the current buffer pointer, then moves the pointer on. When the pointer wraps, the block raises a one-cycle done pulse. The error/feature location is split by direction. Reads return the error byte, which the device side loads. Host writes land only in the feature byte.

Read data and lane enables are registered. They are valid in the cycle after the access strobe.

Top module: `tfd_lane_decoder`

## Requirements
- R1: With both enables low, offsets 0, 1, 8 and 9 are a word access to the data register on D15-D0, whatever A0 is, with lane_oe = 2'b11. A read returns {buf[q+1], buf[q]}, and a write stores D7-D0 at q and D15-D8 at q+1, where q is the pointer with bit 0 cleared.
- R2: With the upper enable high and the lower enable low, a data byte access at the pointer uses D7-D0 with lane_oe = 2'b01. This covers offset 0 or 8 with A0=0, and offset 9 with A0=1.
- R3: With the upper enable low and the lower enable high, offsets 8 and 9 give a data byte access at the pointer on D15-D8, with lane_oe = 2'b10.
- R4: With the upper enable high, the lower enable low and A0=1, offsets 1 and 0xD reach the error/feature location on D7-D0 (lane_oe = 2'b01).
- R5: The error/feature location is reached on D15-D8 (lane_oe = 2'b10) in two cases: upper enable low and lower enable high at offset 0 or 1, or both enables low at offset 0xD.
- R6: A read of the error/feature location returns the error byte. A write loads the feature byte (feat_q) from the active lane and leaves the error byte unchanged.
- R7: On err_load, the error byte captures err_src with bits 5, 3 and 1 forced to 0. The bit meanings are: bit 7 bad block, bit 6 uncorrectable, bit 4 sector ID not found, bit 2 command aborted, bit 0 general error.
- R8: The buffer pointer is 0 after reset. It advances by 2 on each word data access and by 1 on each byte data access, for reads and writes alike. Reset does not clear the buffer contents.
- R9: The pointer wraps modulo 512. buf_done is high for exactly the one cycle after an access that wrapped it.
- R10: An access that decodes to no register, including any access with both enables high, reads as rdata = 0 with lane_oe = 2'b00. As a write it changes neither the buffer, the pointer nor feat_q.
- R11: Read results appear one cycle after the strobe. Writes and idle cycles give rdata = 0 and lane_oe = 2'b00. After reset, rdata, lane_oe, feat_q, err_q and buf_done are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| ce_hi_n | input | 1 | Upper (odd byte) card enable, active low |
| ce_lo_n | input | 1 | Lower (even byte) card enable, active low |
| a0 | input | 1 | Address bit 0 |
| reg_off | input | 4 | Register offset |
| wdata | input | 16 | Host write data |
| err_load | input | 1 | Device-side load of the error byte |
| err_src | input | 8 | Device-side error flags |
| rdata | output | 16 | Host read data, lane-steered |
| lane_oe | output | 2 | Bus drive enables, bit 1 = D15-D8, bit 0 = D7-D0 |
| feat_q | output | 8 | Feature byte last written by the host |
| err_q | output | 8 | Current error byte |
| buf_done | output | 1 | One-cycle pulse after a pointer wrap |

## Verification
Every host-visible result is due exactly one clock after the strobe edge. This holds for read data, lane enables and the buf_done pulse, because each passes through a single register stage; feat_q and err_q also update on that same edge. The bench drives an access on a falling edge, lets one rising edge pass, and compares all outputs on the next falling edge. A reference model built from the requirements supplies the expected values, so each comparison lands in the one cycle where the result is defined and before the next access can disturb it.

// File: rtl/tfd_pkg.sv
package tfd_pkg;
  typedef enum logic [2:0] {
    K_NONE,
    K_WORD,
    K_DLO,
    K_DHI,
    K_ELO,
    K_EHI
  } acc_kind_e;
endpackage

// File: rtl/tfd_decode.sv
module tfd_decode
  import tfd_pkg::*;
(
  input  logic       ce_hi_n,
  input  logic       ce_lo_n,
  input  logic       a0,
  input  logic [3:0] reg_off,
  output acc_kind_e  kind
);
  always_comb begin
    kind = K_NONE;
    unique case ({ce_hi_n, ce_lo_n})
      2'b00: begin
        if (reg_off inside {4'h0, 4'h1, 4'h8, 4'h9}) kind = K_WORD;
        else if (reg_off == 4'hD)                    kind = K_EHI;
      end
      2'b10: begin
        if (!a0 && (reg_off == 4'h0 || reg_off == 4'h8))     kind = K_DLO;
        else if (a0 && reg_off == 4'h9)                      kind = K_DLO;
        else if (a0 && (reg_off == 4'h1 || reg_off == 4'hD)) kind = K_ELO;
      end
      2'b01: begin
        if (reg_off == 4'h8 || reg_off == 4'h9)      kind = K_DHI;
        else if (reg_off == 4'h0 || reg_off == 4'h1) kind = K_EHI;
      end
      default: kind = K_NONE;
    endcase
  end
endmodule

// File: rtl/tfd_sector_buf.sv
module tfd_sector_buf #(
  parameter int BUF_BYTES = 512,
  localparam int ROWS   = BUF_BYTES / 2,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic [ROW_W-1:0] row,
  input  logic [1:0]       we,
  input  logic [15:0]      wd,
  output logic [15:0]      rd
);
  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [7:0] mem [ROWS];
    always_ff @(posedge clk) begin
      if (we[g]) mem[row] <= wd[8*g +: 8];
      rd[8*g +: 8] <= mem[row];
    end
  end
endmodule

// File: rtl/tfd_regs.sv
module tfd_regs #(
  parameter logic [7:0] ERR_MASK = 8'hD5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       err_load,
  input  logic [7:0] err_src,
  input  logic       feat_we,
  input  logic [7:0] feat_d,
  output logic [7:0] err_q,
  output logic [7:0] feat_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      feat_q <= '0;
    end else begin
      if (err_load) err_q <= err_src & ERR_MASK;
      if (feat_we)  feat_q <= feat_d;
    end
  end
endmodule

// File: rtl/tfd_lane_decoder.sv
module tfd_lane_decoder
  import tfd_pkg::*;
#(
  parameter int BUF_BYTES = 512,
  localparam int PTR_W = $clog2(BUF_BYTES),
  localparam int ROW_W = PTR_W - 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        acc_en,
  input  logic        wr_en,
  input  logic        ce_hi_n,
  input  logic        ce_lo_n,
  input  logic        a0,
  input  logic [3:0]  reg_off,
  input  logic [15:0] wdata,
  input  logic        err_load,
  input  logic [7:0]  err_src,
  output logic [15:0] rdata,
  output logic [1:0]  lane_oe,
  output logic [7:0]  feat_q,
  output logic [7:0]  err_q,
  output logic        buf_done
);
  acc_kind_e      kind;
  logic [PTR_W-1:0] ptr;
  logic [PTR_W:0]   ptr_nxt;
  logic           is_data, is_word, is_err;
  logic [7:0]     byte_in;
  logic [1:0]     buf_we;
  logic [15:0]    buf_wd, buf_rd;
  acc_kind_e      rk_q;
  logic           rp0_q;
  logic [7:0]     es_q;

  tfd_decode u_dec (
    .ce_hi_n (ce_hi_n),
    .ce_lo_n (ce_lo_n),
    .a0      (a0),
    .reg_off (reg_off),
    .kind    (kind)
  );

  assign is_word = (kind == K_WORD);
  assign is_data = is_word || kind == K_DLO || kind == K_DHI;
  assign is_err  = (kind == K_ELO) || (kind == K_EHI);
  assign byte_in = (kind == K_DHI || kind == K_EHI) ? wdata[15:8] : wdata[7:0];
  assign ptr_nxt = {1'b0, ptr} + (is_word ? (PTR_W+1)'(2) : (PTR_W+1)'(1));

  always_comb begin
    buf_we = 2'b00;
    if (acc_en && wr_en && is_data)
      buf_we = is_word ? 2'b11 : (ptr[0] ? 2'b10 : 2'b01);
  end
  assign buf_wd = is_word ? wdata : {byte_in, byte_in};

  tfd_sector_buf #(.BUF_BYTES(BUF_BYTES)) u_buf (
    .clk (clk),
    .row (ptr[PTR_W-1:1]),
    .we  (buf_we),
    .wd  (buf_wd),
    .rd  (buf_rd)
  );

  tfd_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .err_load (err_load),
    .err_src  (err_src),
    .feat_we  (acc_en && wr_en && is_err),
    .feat_d   (byte_in),
    .err_q    (err_q),
    .feat_q   (feat_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      buf_done <= 1'b0;
      rk_q     <= K_NONE;
      rp0_q    <= 1'b0;
      es_q     <= '0;
    end else begin
      buf_done <= 1'b0;
      rk_q     <= (acc_en && !wr_en) ? kind : K_NONE;
      rp0_q    <= ptr[0];
      es_q     <= err_q;
      if (acc_en && is_data) begin
        ptr      <= ptr_nxt[PTR_W-1:0];
        buf_done <= ptr_nxt[PTR_W];
      end
    end
  end

  logic [7:0] rbyte;
  assign rbyte = rp0_q ? buf_rd[15:8] : buf_rd[7:0];

  always_comb begin
    rdata   = '0;
    lane_oe = 2'b00;
    unique case (rk_q)
      K_WORD: begin rdata = buf_rd;        lane_oe = 2'b11; end
      K_DLO:  begin rdata = {8'h00, rbyte}; lane_oe = 2'b01; end
      K_DHI:  begin rdata = {rbyte, 8'h00}; lane_oe = 2'b10; end
      K_ELO:  begin rdata = {8'h00, es_q};  lane_oe = 2'b01; end
      K_EHI:  begin rdata = {es_q, 8'h00};  lane_oe = 2'b10; end
      default: ;
    endcase
  end
endmodule

// File: rtl/tfd_lane_decoder_chk.sv
module tfd_lane_decoder_chk (
  input logic        clk,
  input logic        rst,
  input logic        acc_en,
  input logic        wr_en,
  input logic        ce_hi_n,
  input logic        ce_lo_n,
  input logic [3:0]  reg_off,
  input logic        err_load,
  input logic [15:0] rdata,
  input logic [1:0]  lane_oe,
  input logic [7:0]  feat_q,
  input logic [7:0]  err_q,
  input logic        buf_done
);
  // R1
  word_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !wr_en && !ce_hi_n && !ce_lo_n &&
     (reg_off == 4'h0 || reg_off == 4'h1 || reg_off == 4'h8 || reg_off == 4'h9))
    |=> lane_oe == 2'b11);
  // R10
  no_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_en && ce_hi_n && ce_lo_n) |=> (lane_oe == 2'b00 && rdata == 16'h0));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && !wr_en) |=> (lane_oe == 2'b00 && rdata == 16'h0));
  // R6
  err_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !err_load |=> $stable(err_q));
  // R6
  feat_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && wr_en) |=> $stable(feat_q));
  // R7
  err_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q & 8'h2A) == 8'h00);
  // R9
  done_needs_acc_chk: assert property (@(posedge clk) disable iff (rst)
    !acc_en |=> !buf_done);
endmodule

bind tfd_lane_decoder tfd_lane_decoder_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_en   (acc_en),
  .wr_en    (wr_en),
  .ce_hi_n  (ce_hi_n),
  .ce_lo_n  (ce_lo_n),
  .reg_off  (reg_off),
  .err_load (err_load),
  .rdata    (rdata),
  .lane_oe  (lane_oe),
  .feat_q   (feat_q),
  .err_q    (err_q),
  .buf_done (buf_done)
);

// File: tb/tfd_lane_decoder_tb_top.sv
`timescale 1ns/1ps
module tfd_lane_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_en = 1'b0, wr_en = 1'b0, ce_hi_n = 1'b1, ce_lo_n = 1'b1, a0 = 1'b0;
  logic [3:0]  reg_off = '0;
  logic [15:0] wdata = '0;
  logic        err_load = 1'b0;
  logic [7:0]  err_src = '0;
  logic [15:0] rdata;
  logic [1:0]  lane_oe;
  logic [7:0]  feat_q, err_q;
  logic        buf_done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tfd_lane_decoder dut_i (
    .clk(clk), .rst(rst), .acc_en(acc_en), .wr_en(wr_en),
    .ce_hi_n(ce_hi_n), .ce_lo_n(ce_lo_n), .a0(a0), .reg_off(reg_off),
    .wdata(wdata), .err_load(err_load), .err_src(err_src),
    .rdata(rdata), .lane_oe(lane_oe), .feat_q(feat_q), .err_q(err_q),
    .buf_done(buf_done)
  );

  // reference state
  logic [7:0] m_mem [512];
  int         m_ptr = 0;
  logic [7:0] m_err = '0, m_feat = '0;

  // {hi_n, lo_n, a0, off[3:0], wr, wdata[15:0], exp_oe[1:0]}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,4'h0,1'b0,16'h0,2'b11},
    {1'b0,1'b0,1'b1,4'h1,1'b0,16'h0,2'b11},
    {1'b0,1'b0,1'b0,4'h9,1'b0,16'h0,2'b11},
    {1'b1,1'b0,1'b0,4'h8,1'b0,16'h0,2'b01},
    {1'b1,1'b0,1'b1,4'h9,1'b0,16'h0,2'b01},
    {1'b1,1'b0,1'b1,4'h1,1'b0,16'h0,2'b01},
    {1'b1,1'b0,1'b1,4'hD,1'b0,16'h0,2'b01},
    {1'b0,1'b1,1'b0,4'h8,1'b0,16'h0,2'b10},
    {1'b0,1'b1,1'b1,4'h9,1'b0,16'h0,2'b10},
    {1'b0,1'b1,1'b0,4'h0,1'b0,16'h0,2'b10},
    {1'b0,1'b0,1'b0,4'hD,1'b0,16'h0,2'b10},
    {1'b1,1'b1,1'b0,4'h0,1'b0,16'h0,2'b00},
    {1'b1,1'b0,1'b0,4'h2,1'b0,16'h0,2'b00}
  };

  // 0 none, 1 word, 2 data low, 3 data high, 4 err low, 5 err high
  function automatic int ref_kind(bit h, bit l, bit a, logic [3:0] o);
    if (!h && !l) return (o == 0 || o == 1 || o == 8 || o == 9) ? 1 : (o == 13 ? 5 : 0);
    if (h && !l) begin
      if ((!a && (o == 0 || o == 8)) || (a && o == 9)) return 2;
      if (a && (o == 1 || o == 13)) return 4;
      return 0;
    end
    if (!h && l) begin
      if (o == 8 || o == 9) return 3;
      if (o == 0 || o == 1) return 5;
    end
    return 0;
  endfunction

  function automatic string req_of(int k);
    case (k)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(bit h, bit l, bit a, logic [3:0] o, bit w, logic [15:0] d,
                        bit chk_all);
    int k, q, step, e_done;
    logic [15:0] e_rd;
    logic [1:0]  e_oe;
    k = ref_kind(h, l, a, o);
    e_rd = '0; e_oe = 2'b00; e_done = 0;
    q = m_ptr & ~1;
    if (k >= 1 && k <= 3) begin
      if (w) begin
        if (k == 1) begin m_mem[q] = d[7:0]; m_mem[q+1] = d[15:8]; end
        else m_mem[m_ptr] = (k == 3) ? d[15:8] : d[7:0];
      end else begin
        if (k == 1) begin e_rd = {m_mem[q+1], m_mem[q]}; e_oe = 2'b11; end
        else if (k == 2) begin e_rd = {8'h00, m_mem[m_ptr]}; e_oe = 2'b01; end
        else begin e_rd = {m_mem[m_ptr], 8'h00}; e_oe = 2'b10; end
      end
      step = (k == 1) ? 2 : 1;
      e_done = (m_ptr + step >= 512);
      m_ptr = (m_ptr + step) % 512;
    end else if (k >= 4) begin
      if (w) m_feat = (k == 5) ? d[15:8] : d[7:0];
      else begin
        e_rd = (k == 5) ? {m_err, 8'h00} : {8'h00, m_err};
        e_oe = (k == 5) ? 2'b10 : 2'b01;
      end
    end
    ce_hi_n = h; ce_lo_n = l; a0 = a; reg_off = o; wr_en = w; wdata = d;
    acc_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_en = 1'b0;
    if (chk_all || !w) begin
      check(req_of(k), {16'h0, rdata}, {16'h0, e_rd});
      check(req_of(k), {30'h0, lane_oe}, {30'h0, e_oe});
    end
    if (chk_all) begin
      check("R9", {31'h0, buf_done}, e_done);
      check("R6", {24'h0, feat_q}, {24'h0, m_feat});
      check("R6", {24'h0, err_q}, {24'h0, m_err});
    end
  endtask

  task automatic load_err(logic [7:0] v);
    err_src = v; err_load = 1'b1;
    m_err = v & 8'hD5;
    @(posedge clk);
    @(negedge clk);
    err_load = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_ptr = 0; m_feat = '0; m_err = '0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) m_mem[i] = '0;
    @(negedge clk);
    do_reset();
    // R11 reset state
    check("R11", {16'h0, rdata}, 32'h0);
    check("R11", {30'h0, lane_oe}, 32'h0);
    check("R11", {24'h0, feat_q, err_q}, 32'h0);
    check("R11", {31'h0, buf_done}, 32'h0);

    // R7 error bit layout, reserved bits read 0
    load_err(8'hFF);
    check("R7", {24'h0, err_q}, 32'hD5);
    load_err(8'h2A);
    check("R7", {24'h0, err_q}, 32'h00);
    load_err(8'h95);

    // R8 fill the buffer with word writes; last one wraps (R9)
    for (int i = 0; i < 256; i++)
      access(1'b0, 1'b0, 1'b0, 4'h0, 1'b1, {8'(i) ^ 8'hA5, 8'(i)}, 1'b1);

    // table walk of lane placement
    for (int v = 0; v < NV; v++) begin
      logic [25:0] e;
      e = VEC[v];
      access(e[25], e[24], e[23], e[22:19], e[18], e[17:2], 1'b1);
      check(req_of(ref_kind(e[25], e[24], e[23], e[22:19])), {30'h0, lane_oe}, {30'h0, e[1:0]});
    end

    // R6 feature write on each lane, error untouched, then read back error
    access(1'b1, 1'b0, 1'b1, 4'h1, 1'b1, 16'h003C, 1'b1);
    check("R6", {24'h0, feat_q}, 32'h3C);
    access(1'b0, 1'b1, 1'b0, 4'h0, 1'b1, 16'hC300, 1'b1);
    check("R6", {24'h0, feat_q}, 32'hC3);
    access(1'b1, 1'b0, 1'b1, 4'hD, 1'b0, 16'h0, 1'b1);
    check("R6", {16'h0, rdata}, 32'h0095);

    // full sweep of enables, A0, offset and direction
    for (int c = 0; c < 128; c++) begin
      bit wsel;
      wsel = c[0];
      access(c[6], c[5], c[4], c[3:0] ^ 4'(c >> 7), wsel, 16'(c * 16'h1357), 1'b1);
    end
    for (int c = 0; c < 64; c++)
      access(c[5], c[4], c[0], c[3:0], 1'b0, 16'h0, 1'b1);

    // R8 pointer restarts at 0 after reset, buffer retained; byte walk wraps (R9)
    do_reset();
    for (int i = 0; i < 256; i++)
      access(1'b0, 1'b0, 1'b0, 4'h8, 1'b0, 16'h0, 1'b1);
    do_reset();
    for (int i = 0; i < 512; i++)
      access(1'b1, 1'b0, 1'b0, 4'h0, 1'b0, 16'h0, 1'b1);

    // R10 undefined write leaves pointer and buffer; next byte read proves it
    access(1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 16'hFFFF, 1'b1);
    access(1'b0, 1'b0, 1'b0, 4'h5, 1'b1, 16'hFFFF, 1'b1);
    access(1'b0, 1'b1, 1'b1, 4'h9, 1'b0, 16'h0, 1'b1);
    check("R10", {24'h0, rdata[15:8]}, {24'h0, m_mem[(m_ptr + 511) % 512]});

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule